// File: doc/BRIEF.md
# E3 Frame-Master Transmit Timing Generator

This block is the timing master on the transmit side of an E3 framer. It sets the frame rhythm and the payload source follows it. Each clock cycle is one bit period, and the block tracks which bit position of the outbound frame is being processed. It raises a frame strobe on the final position of every frame. The source treats that strobe as the cue to present the first bit of the next frame. One bit period before every overhead position, the block raises an overhead-indicate strobe. The source then holds its next payload bit back by one cycle.

On every rising edge the block latches the serial input. One cycle later it presents that bit together with a flag. The flag is high only when the bit was latched during a payload position. Bits latched during overhead positions come out with the flag low and are discarded. The block produces positions and strobes only. Alignment words and other overhead content are assembled elsewhere. The frame is `FRAME_BITS` positions long (1536 by default). The first `OH_BITS` positions (12 by default) are overhead.

A three-state machine tracks the position:

- `ST_HEAD` covers positions 0 to 11. It moves to `ST_BODY` after position 11.
- `ST_BODY` covers positions 12 to 1534. It moves to `ST_TAIL` after position 1534.
- `ST_TAIL` is position 1535. It always moves to `ST_HEAD`.

Reset enters `ST_TAIL`.

Top module: `e3tx_frame_master`

## Requirements
- R1: While `rst` is high at a rising edge, the block is forced to its start state. In the first cycle after `rst` falls, `bit_pos` is 1535, `frame_strb` is 1, `oh_ind` is 1 and `bit_is_pay` is 0. This holds even when reset arrives in the middle of a frame.
- R2: `bit_pos` rises by one on each rising edge outside reset, and wraps from 1535 to 0.
- R3: `frame_strb` is 1 exactly in the cycles where `bit_pos` is 1535, so it is a single-cycle pulse once per frame.
- R4: `oh_ind` is 1 exactly when `bit_pos` is 1535 or lies in 0 to 10. It therefore leads each overhead position 0 to 11 by one cycle.
- R5: `bit_out` equals the value `ser_in` had at the previous rising edge.
- R6: `bit_is_pay` is 1 exactly when the previous cycle's `bit_pos` was 12 or greater. Bits latched at positions 0 to 11 carry `bit_is_pay` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one bit period per cycle |
| rst | input | 1 | Synchronous reset, active high |
| ser_in | input | 1 | Serial payload from the source, latched on the rising edge |
| frame_strb | output | 1 | High while the last position of the frame is processed |
| oh_ind | output | 1 | High one bit period before each overhead position |
| bit_pos | output | 11 | Current bit position within the frame |
| bit_out | output | 1 | Bit latched at the previous rising edge |
| bit_is_pay | output | 1 | High when `bit_out` was latched at a payload position |

## Verification
The assertions take `rst` to be synchronous and free of glitches. They also assume `ser_in` is settled at each rising edge, because the payload tag and the latched bit are tied to the position of the cycle in which the bit was sampled. The bench meets both assumptions by changing `rst` and `ser_in` only on falling edges. It feeds a pseudo-random bit stream across several whole frames, so every position, including both wrap points, is covered. It also asserts reset once in the middle of a frame, to show that the start state does not depend on where the counter stood.

// File: rtl/e3tx_pkg.sv
package e3tx_pkg;

    // Region of the frame the position counter is in
    typedef enum logic [1:0] {
        ST_HEAD = 2'd0,   // overhead positions
        ST_BODY = 2'd1,   // payload positions before the last
        ST_TAIL = 2'd2    // final position of the frame
    } e3tx_region_t;

endpackage

// File: rtl/e3tx_pos_fsm.sv
module e3tx_pos_fsm
    import e3tx_pkg::*;
#(
    parameter int FRAME_BITS = 1536,
    parameter int OH_BITS    = 12,
    localparam int POS_W     = $clog2(FRAME_BITS)
) (
    input  logic             clk,
    input  logic             rst,
    output logic [POS_W-1:0] pos_q,
    output logic [POS_W-1:0] pos_nxt,
    output e3tx_region_t     region_q,
    output e3tx_region_t     region_nxt
);

    localparam logic [POS_W-1:0] LAST_POS   = POS_W'(FRAME_BITS - 1);
    localparam logic [POS_W-1:0] PRELAST    = POS_W'(FRAME_BITS - 2);
    localparam logic [POS_W-1:0] OH_END_POS = POS_W'(OH_BITS - 1);

    // State register process
    always_ff @(posedge clk) begin
        if (rst) begin
            region_q <= ST_TAIL;
            pos_q    <= LAST_POS;
        end else begin
            region_q <= region_nxt;
            pos_q    <= pos_nxt;
        end
    end

    // Next-state and position process
    always_comb begin
        region_nxt = region_q;
        pos_nxt    = pos_q + 1'b1;
        unique case (region_q)
            ST_HEAD: begin
                if (pos_q == OH_END_POS) region_nxt = ST_BODY;
            end
            ST_BODY: begin
                if (pos_q == PRELAST) region_nxt = ST_TAIL;
            end
            ST_TAIL: begin
                region_nxt = ST_HEAD;
                pos_nxt    = '0;
            end
            default: begin
                region_nxt = ST_TAIL;
                pos_nxt    = LAST_POS;
            end
        endcase
    end

    assert_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        (pos_q == LAST_POS) |=> (pos_q == '0));
    assert_step_R2: assert property (@(posedge clk) disable iff (rst)
        (pos_q != LAST_POS) |=> (pos_q == POS_W'($past(pos_q) + 1'b1)));
    assert_region_R2: assert property (@(posedge clk) disable iff (rst)
        (region_q == ST_HEAD) |-> (pos_q < POS_W'(OH_BITS)));

endmodule

// File: rtl/e3tx_strobe_gen.sv
module e3tx_strobe_gen
    import e3tx_pkg::*;
#(
    parameter int FRAME_BITS = 1536,
    parameter int OH_BITS    = 12,
    localparam int POS_W     = $clog2(FRAME_BITS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [POS_W-1:0] pos_q,
    input  logic [POS_W-1:0] pos_nxt,
    input  e3tx_region_t     region_nxt,
    output logic             frame_strb,
    output logic             oh_ind
);

    localparam logic [POS_W-1:0] OH_END_POS = POS_W'(OH_BITS - 1);
    localparam logic [POS_W-1:0] LAST_POS   = POS_W'(FRAME_BITS - 1);

    logic strb_d;
    logic ohi_d;

    // Decode of the position entered at the next edge
    always_comb begin
        strb_d = (region_nxt == ST_TAIL);
        // position after next is overhead: next is last, or next is head but not its final slot
        ohi_d  = (region_nxt == ST_TAIL) ||
                 ((region_nxt == ST_HEAD) && (pos_nxt != OH_END_POS));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_strb <= 1'b1;
            oh_ind     <= 1'b1;
        end else begin
            frame_strb <= strb_d;
            oh_ind     <= ohi_d;
        end
    end

    assert_strb_pos_R3: assert property (@(posedge clk) disable iff (rst)
        frame_strb == (pos_q == LAST_POS));
    assert_strb_single_R3: assert property (@(posedge clk) disable iff (rst)
        frame_strb |=> !frame_strb);
    assert_oh_lead_R4: assert property (@(posedge clk) disable iff (rst)
        oh_ind |=> (pos_q < POS_W'(OH_BITS)));
    assert_oh_cover_R4: assert property (@(posedge clk) disable iff (rst)
        ((pos_q < OH_END_POS) || (pos_q == LAST_POS)) |-> oh_ind);

endmodule

// File: rtl/e3tx_payload_tap.sv
module e3tx_payload_tap #(
    parameter int FRAME_BITS = 1536,
    parameter int OH_BITS    = 12,
    localparam int POS_W     = $clog2(FRAME_BITS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ser_in,
    input  logic [POS_W-1:0] pos_q,
    output logic             bit_out,
    output logic             bit_is_pay
);

    localparam logic [POS_W-1:0] FIRST_PAY = POS_W'(OH_BITS);

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_out    <= 1'b0;
            bit_is_pay <= 1'b0;
        end else begin
            bit_out    <= ser_in;
            bit_is_pay <= (pos_q >= FIRST_PAY);
        end
    end

    assert_tag_R6: assert property (@(posedge clk) disable iff (rst)
        bit_is_pay |-> ($past(pos_q) >= FIRST_PAY));
    assert_oh_drop_R6: assert property (@(posedge clk) disable iff (rst)
        (pos_q < FIRST_PAY) |=> !bit_is_pay);

endmodule

// File: rtl/e3tx_frame_master.sv
module e3tx_frame_master
    import e3tx_pkg::*;
#(
    parameter int FRAME_BITS = 1536,
    parameter int OH_BITS    = 12,
    localparam int POS_W     = $clog2(FRAME_BITS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ser_in,
    output logic             frame_strb,
    output logic             oh_ind,
    output logic [POS_W-1:0] bit_pos,
    output logic             bit_out,
    output logic             bit_is_pay
);

    logic [POS_W-1:0] pos_q;
    logic [POS_W-1:0] pos_nxt;
    e3tx_region_t     region_q;
    e3tx_region_t     region_nxt;

    e3tx_pos_fsm #(.FRAME_BITS(FRAME_BITS), .OH_BITS(OH_BITS)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .pos_q      (pos_q),
        .pos_nxt    (pos_nxt),
        .region_q   (region_q),
        .region_nxt (region_nxt)
    );

    e3tx_strobe_gen #(.FRAME_BITS(FRAME_BITS), .OH_BITS(OH_BITS)) u_strb (
        .clk        (clk),
        .rst        (rst),
        .pos_q      (pos_q),
        .pos_nxt    (pos_nxt),
        .region_nxt (region_nxt),
        .frame_strb (frame_strb),
        .oh_ind     (oh_ind)
    );

    e3tx_payload_tap #(.FRAME_BITS(FRAME_BITS), .OH_BITS(OH_BITS)) u_tap (
        .clk        (clk),
        .rst        (rst),
        .ser_in     (ser_in),
        .pos_q      (pos_q),
        .bit_out    (bit_out),
        .bit_is_pay (bit_is_pay)
    );

    assign bit_pos = pos_q;

    assert_reset_R1: assert property (@(posedge clk)
        $past(rst) && !rst |-> (frame_strb && oh_ind && !bit_is_pay && region_q == ST_TAIL));

endmodule

// File: tb/sim_e3tx_frame_master.sv
module sim_e3tx_frame_master;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ser_in = 1'b0;
    logic        frame_strb, oh_ind, bit_out, bit_is_pay;
    logic [10:0] bit_pos;

    int n_chk = 0;
    int n_bad = 0;
    int m_pos;
    bit m_bit;
    bit m_pay;
    bit done = 1'b0;

    always #2 clk = ~clk;

    e3tx_frame_master u0 (
        .clk(clk), .rst(rst), .ser_in(ser_in),
        .frame_strb(frame_strb), .oh_ind(oh_ind), .bit_pos(bit_pos),
        .bit_out(bit_out), .bit_is_pay(bit_is_pay)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string rq);
        chk(rq == "" ? "R2" : rq, "bit_pos", int'(bit_pos), m_pos);
        chk(rq == "" ? "R3" : rq, "frame_strb", int'(frame_strb), int'(m_pos == 1535));
        chk(rq == "" ? "R4" : rq, "oh_ind", int'(oh_ind), int'(m_pos == 1535 || m_pos <= 10));
        chk(rq == "" ? "R5" : rq, "bit_out", int'(bit_out), int'(m_bit));
        chk(rq == "" ? "R6" : rq, "bit_is_pay", int'(bit_is_pay), int'(m_pay));
    endtask

    task automatic do_reset();
        @(negedge clk) rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_pos = 1535; m_bit = 1'b0; m_pay = 1'b0;
        check_all("R1");
    endtask

    task automatic run(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            bit b;
            b = 1'($urandom);
            ser_in = b;
            @(negedge clk);
            m_bit = b;
            m_pay = (m_pos >= 12);
            m_pos = (m_pos + 1) % 1536;
            check_all("");
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        do_reset();
        run(1536 * 3 + 20);
        run(700);          // stop mid-frame
        do_reset();        // R1 mid-frame reset
        run(1536 + 40);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule